// File: doc/BRIEF.md
# Programmable Address-Valid Strobe Generator

This block drives the active-low address-valid strobe of an external memory bus controller. Each access opens with a one-cycle start pulse. From that pulse a cycle counter runs, and the strobe goes low over a window. The window opens at a programmed assertion count and closes at a programmed de-assertion count. Reads and writes have separate close counts. In a two-phase multiplexed address mode (address, address, data), the first address phase uses its own narrower set of open and close counts. An optional setting moves every strobe edge half a clock cycle later.

Software sets the timing through a single 32-bit configuration word, written over a simple write-enable port and always readable. Each access captures the timing in force at its start pulse. A write to the word during an access therefore takes effect only at the next start. A start pulse that arrives while an access is still running restarts the count and loads the timing for the new access's direction.

Top module: `avs_strobe_gen`

## Requirements
- R1: After a synchronous reset, `cfg_rd_data` reads 0x2206_0514. This is open count 4, first-phase open 1, read close 5, write close 6, first-phase read close 2, first-phase write close 2 and half-cycle delay off. `adv_n` is high.
- R2: A configuration write stores the fields at these bits: open count [3:0], first-phase open [6:4], half-cycle delay [7], read close [12:8], write close [20:16], first-phase read close [26:24], first-phase write close [30:28]. Bits 31, 27, 23:21 and 15:13 always read 0, so writing all ones reads back 0x771F_1FFF.
- R3: Cycle 0 of an access is the clock period after the edge that samples `acc_start`. In normal mode a read (`acc_is_write`=0) drives `adv_n` low exactly in cycles k where open ≤ k < read close.
- R4: In normal mode a write (`acc_is_write`=1) drives `adv_n` low exactly in cycles k where open ≤ k < write close.
- R5: If the selected close count is less than or equal to the open count, `adv_n` stays high for the whole access.
- R6: The access counter saturates at 31. With open 0 and close 31, `adv_n` is low for cycles 0 to 30, then stays high until the next start.
- R7: With the delay bit set, every `adv_n` edge moves half a clock period later than with the bit clear. The value in cycle k then holds from the falling edge inside cycle k until the falling edge inside cycle k+1.
- R8: With `aad_mode_en`=1 at the start pulse, the access uses the first-phase open count, and the first-phase read close or first-phase write close according to direction.
- R9: A start pulse during a running access restarts counting at cycle 0. It applies the open and close counts of the new access's direction.
- R10: Open, close and delay settings are captured at the start pulse. A configuration write during an access does not alter that access.
- R11: From reset until the first start pulse, `adv_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_start | input | 1 | One-cycle pulse opening an access |
| acc_is_write | input | 1 | Direction of the access opened by `acc_start` (1 = write) |
| aad_mode_en | input | 1 | Selects first-phase timing of the multiplexed address mode |
| cfg_wr_en | input | 1 | Configuration word write strobe |
| cfg_wr_data | input | 32 | Configuration word write value |
| cfg_rd_data | output | 32 | Current configuration word, reserved bits zero |
| adv_n | output | 1 | Active-low address-valid strobe |

## Verification
The bench builds the block with its default parameters: 4-bit open count, 5-bit close counts and 3-bit first-phase counts. These widths let it reach counter saturation at 31 within a short access. They also let it program both a close count below the open count and a close count equal to it. The scoreboard samples `adv_n` twice per cycle, after the rising edge and after the falling edge. This lets it tell the half-cycle delayed strobe from the undelayed one, including across a restart that changes direction.

// File: rtl/avs_pkg.sv
`timescale 1ns/1ps
package avs_pkg;
  parameter int ON_W  = 4;
  parameter int OFF_W = 5;
  parameter int PH1_W = 3;
  parameter int CFG_W = 32;

  localparam int CNT_W = OFF_W;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  localparam int POS_ON     = 0;
  localparam int POS_PH1_ON = 4;
  localparam int POS_DLY    = 7;
  localparam int POS_RD     = 8;
  localparam int POS_WR     = 16;
  localparam int POS_PH1_RD = 24;
  localparam int POS_PH1_WR = 28;

  localparam int DEF_ON     = 4;
  localparam int DEF_PH1_ON = 1;
  localparam int DEF_DLY    = 0;
  localparam int DEF_RD     = 5;
  localparam int DEF_WR     = 6;
  localparam int DEF_PH1_RD = 2;
  localparam int DEF_PH1_WR = 2;

  typedef struct packed {
    logic [PH1_W-1:0] ph1_wr_off;
    logic [PH1_W-1:0] ph1_rd_off;
    logic [OFF_W-1:0] wr_off;
    logic [OFF_W-1:0] rd_off;
    logic             half_dly;
    logic [PH1_W-1:0] ph1_on;
    logic [ON_W-1:0]  on;
  } avs_cfg_t;
endpackage

// File: rtl/avs_cfg_reg.sv
`timescale 1ns/1ps
module avs_cfg_reg
  import avs_pkg::*;
#(
  parameter int RST_ON     = DEF_ON,
  parameter int RST_PH1_ON = DEF_PH1_ON,
  parameter int RST_DLY    = DEF_DLY,
  parameter int RST_RD     = DEF_RD,
  parameter int RST_WR     = DEF_WR,
  parameter int RST_PH1_RD = DEF_PH1_RD,
  parameter int RST_PH1_WR = DEF_PH1_WR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output avs_cfg_t         cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.on         <= ON_W'(RST_ON);
      cfg.ph1_on     <= PH1_W'(RST_PH1_ON);
      cfg.half_dly   <= 1'(RST_DLY);
      cfg.rd_off     <= OFF_W'(RST_RD);
      cfg.wr_off     <= OFF_W'(RST_WR);
      cfg.ph1_rd_off <= PH1_W'(RST_PH1_RD);
      cfg.ph1_wr_off <= PH1_W'(RST_PH1_WR);
    end else if (wr_en) begin
      cfg.on         <= wr_data[POS_ON     +: ON_W];
      cfg.ph1_on     <= wr_data[POS_PH1_ON +: PH1_W];
      cfg.half_dly   <= wr_data[POS_DLY];
      cfg.rd_off     <= wr_data[POS_RD     +: OFF_W];
      cfg.wr_off     <= wr_data[POS_WR     +: OFF_W];
      cfg.ph1_rd_off <= wr_data[POS_PH1_RD +: PH1_W];
      cfg.ph1_wr_off <= wr_data[POS_PH1_WR +: PH1_W];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[POS_ON     +: ON_W]  = cfg.on;
    rd_data[POS_PH1_ON +: PH1_W] = cfg.ph1_on;
    rd_data[POS_DLY]             = cfg.half_dly;
    rd_data[POS_RD     +: OFF_W] = cfg.rd_off;
    rd_data[POS_WR     +: OFF_W] = cfg.wr_off;
    rd_data[POS_PH1_RD +: PH1_W] = cfg.ph1_rd_off;
    rd_data[POS_PH1_WR +: PH1_W] = cfg.ph1_wr_off;
  end
endmodule

// File: rtl/avs_timing_sel.sv
`timescale 1ns/1ps
module avs_timing_sel
  import avs_pkg::*;
(
  input  avs_cfg_t         cfg,
  input  logic             is_write,
  input  logic             aad_mode,
  output logic [CNT_W-1:0] on_sel,
  output logic [CNT_W-1:0] off_sel
);
  always_comb begin
    if (aad_mode) begin
      on_sel  = CNT_W'(cfg.ph1_on);
      off_sel = is_write ? CNT_W'(cfg.ph1_wr_off) : CNT_W'(cfg.ph1_rd_off);
    end else begin
      on_sel  = CNT_W'(cfg.on);
      off_sel = is_write ? CNT_W'(cfg.wr_off) : CNT_W'(cfg.rd_off);
    end
  end
endmodule

// File: rtl/avs_timer.sv
`timescale 1ns/1ps
module avs_timer
  import avs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] on_sel,
  input  logic [CNT_W-1:0] off_sel,
  input  logic             dly_sel,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] on_q,
  output logic [CNT_W-1:0] off_q,
  output logic             dly_q,
  output logic             adv_q
);
  logic [CNT_W-1:0] cnt_nxt, on_nxt, off_nxt;

  always_comb begin
    if (start) begin
      cnt_nxt = '0;
      on_nxt  = on_sel;
      off_nxt = off_sel;
    end else begin
      cnt_nxt = (cnt == CNT_W'(CNT_MAX)) ? cnt : cnt + 1'b1;
      on_nxt  = on_q;
      off_nxt = off_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= CNT_W'(CNT_MAX);
      on_q  <= '0;
      off_q <= '0;
      dly_q <= 1'b0;
      adv_q <= 1'b1;
    end else begin
      cnt   <= cnt_nxt;
      on_q  <= on_nxt;
      off_q <= off_nxt;
      if (start) dly_q <= dly_sel;
      adv_q <= !((cnt_nxt >= on_nxt) && (cnt_nxt < off_nxt));
    end
  end
endmodule

// File: rtl/avs_half_delay.sv
`timescale 1ns/1ps
module avs_half_delay (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic use_dly,
  output logic din_neg,
  output logic dout
);
  always_ff @(negedge clk) begin
    if (rst) din_neg <= 1'b1;
    else     din_neg <= din;
  end

  assign dout = use_dly ? din_neg : din;
endmodule

// File: rtl/avs_strobe_gen.sv
`timescale 1ns/1ps
module avs_strobe_gen
  import avs_pkg::*;
#(
  parameter int RST_ON     = DEF_ON,
  parameter int RST_PH1_ON = DEF_PH1_ON,
  parameter int RST_DLY    = DEF_DLY,
  parameter int RST_RD     = DEF_RD,
  parameter int RST_WR     = DEF_WR,
  parameter int RST_PH1_RD = DEF_PH1_RD,
  parameter int RST_PH1_WR = DEF_PH1_WR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_start,
  input  logic             acc_is_write,
  input  logic             aad_mode_en,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  output logic             adv_n
);
  localparam logic [CFG_W-1:0] RST_WORD =
      (CFG_W'(RST_ON)     << POS_ON)     | (CFG_W'(RST_PH1_ON) << POS_PH1_ON) |
      (CFG_W'(RST_DLY)    << POS_DLY)    | (CFG_W'(RST_RD)     << POS_RD)     |
      (CFG_W'(RST_WR)     << POS_WR)     | (CFG_W'(RST_PH1_RD) << POS_PH1_RD) |
      (CFG_W'(RST_PH1_WR) << POS_PH1_WR);

  avs_cfg_t         cfg;
  logic [CNT_W-1:0] on_sel, off_sel;
  logic [CNT_W-1:0] cnt_w, on_w, off_w;
  logic             dly_w, adv_reg_w, adv_neg_w;

  avs_cfg_reg #(
    .RST_ON(RST_ON), .RST_PH1_ON(RST_PH1_ON), .RST_DLY(RST_DLY),
    .RST_RD(RST_RD), .RST_WR(RST_WR),
    .RST_PH1_RD(RST_PH1_RD), .RST_PH1_WR(RST_PH1_WR)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data), .cfg(cfg)
  );

  avs_timing_sel u_sel (
    .cfg(cfg), .is_write(acc_is_write), .aad_mode(aad_mode_en),
    .on_sel(on_sel), .off_sel(off_sel)
  );

  avs_timer u_tmr (
    .clk(clk), .rst(rst), .start(acc_start),
    .on_sel(on_sel), .off_sel(off_sel), .dly_sel(cfg.half_dly),
    .cnt(cnt_w), .on_q(on_w), .off_q(off_w), .dly_q(dly_w), .adv_q(adv_reg_w)
  );

  avs_half_delay u_hd (
    .clk(clk), .rst(rst), .din(adv_reg_w), .use_dly(dly_w),
    .din_neg(adv_neg_w), .dout(adv_n)
  );
endmodule

// File: rtl/avs_strobe_chk.sv
`timescale 1ns/1ps
module avs_strobe_chk
  import avs_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_WORD = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_start,
  input logic [CFG_W-1:0] cfg_rd_data,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] on_q,
  input logic [CNT_W-1:0] off_q,
  input logic             adv_q,
  input logic             adv_neg
);
  localparam logic [CFG_W-1:0] RSVD_MASK =
      ~((CFG_W'((1 << ON_W) - 1)  << POS_ON)     | (CFG_W'((1 << PH1_W) - 1) << POS_PH1_ON) |
        (CFG_W'(1)                << POS_DLY)    | (CFG_W'((1 << OFF_W) - 1) << POS_RD)     |
        (CFG_W'((1 << OFF_W) - 1) << POS_WR)     | (CFG_W'((1 << PH1_W) - 1) << POS_PH1_RD) |
        (CFG_W'((1 << PH1_W) - 1) << POS_PH1_WR));

  AST_RESET_WORD: assert property (@(posedge clk) rst |=> (cfg_rd_data == RST_WORD)); // R1
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst) (cfg_rd_data & RSVD_MASK) == '0); // R2
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst) acc_start |=> (cnt == '0)); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!acc_start && cnt != CNT_W'(CNT_MAX)) |=> (cnt == $past(cnt) + 1'b1)); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!acc_start && cnt == CNT_W'(CNT_MAX)) |=> (cnt == CNT_W'(CNT_MAX))); // R6
  AST_HIGH_AT_SAT: assert property (@(posedge clk) disable iff (rst) (cnt == CNT_W'(CNT_MAX)) |-> adv_q); // R6
  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (rst) (off_q <= on_q) |-> adv_q); // R5
  AST_TIMING_HELD: assert property (@(posedge clk) disable iff (rst)
    !acc_start |=> ($stable(on_q) && $stable(off_q))); // R10
  AST_HALF_FOLLOW: assert property (@(posedge clk) disable iff (rst) adv_neg == adv_q); // R7
endmodule

bind avs_strobe_gen avs_strobe_chk #(.RST_WORD(RST_WORD)) u_chk (
  .clk(clk), .rst(rst), .acc_start(acc_start), .cfg_rd_data(cfg_rd_data),
  .cnt(cnt_w), .on_q(on_w), .off_q(off_w), .adv_q(adv_reg_w), .adv_neg(adv_neg_w)
);

// File: tb/test_avs_strobe_gen.sv
`timescale 1ns/1ps
module test_avs_strobe_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_start = 1'b0;
  logic        acc_is_write = 1'b0;
  logic        aad_mode_en = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        adv_n;

  always #2 clk = ~clk;

  avs_strobe_gen i_avs_strobe_gen (
    .clk(clk), .rst(rst), .acc_start(acc_start), .acc_is_write(acc_is_write),
    .aad_mode_en(aad_mode_en), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .adv_n(adv_n)
  );

  typedef struct {
    logic  early;
    logic  late;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // shadow configuration
  int sh_on = 4, sh_ph1_on = 1, sh_dly = 0, sh_rd = 5, sh_wr = 6, sh_ph1_rd = 2, sh_ph1_wr = 2;
  // access model state
  int m_k = 31, m_on = 0, m_off = 0, m_dly = 0;
  logic m_prev = 1'b1;

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_one(input string tag);
    exp_t e;
    logic v;
    v = !((m_k >= m_on) && (m_k < m_off));
    e.early = m_dly ? m_prev : v;
    e.late  = v;
    e.tag   = tag;
    exp_q.push_back(e);
    m_prev = v;
    if (m_k < 31) m_k++;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) push_one(tag);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [31:0] d, input string tag);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    push_one(tag);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    sh_on     = int'(d[3:0]);
    sh_ph1_on = int'(d[6:4]);
    sh_dly    = int'(d[7]);
    sh_rd     = int'(d[12:8]);
    sh_wr     = int'(d[20:16]);
    sh_ph1_rd = int'(d[26:24]);
    sh_ph1_wr = int'(d[30:28]);
  endtask

  task automatic start_access(input logic wr, input logic aad, input string tag);
    acc_start    = 1'b1;
    acc_is_write = wr;
    aad_mode_en  = aad;
    m_k   = 0;
    m_dly = sh_dly;
    m_on  = aad ? sh_ph1_on : sh_on;
    if (aad) m_off = wr ? sh_ph1_wr : sh_ph1_rd;
    else     m_off = wr ? sh_wr : sh_rd;
    push_one(tag);
    @(negedge clk);
    acc_start = 1'b0;
  endtask

  // monitor: one expected item per cycle, sampled after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        check_val({exp_q[0].tag, " early"}, {31'd0, adv_n}, {31'd0, exp_q[0].early});
        #2;
        check_val({exp_q[0].tag, " late"}, {31'd0, adv_n}, {31'd0, exp_q[0].late});
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_val("R1 reset word", cfg_rd_data, 32'h2206_0514);
    run(5, "R11 idle high");

    start_access(1'b0, 1'b0, "R3 read default");
    run(11, "R3 read default");
    start_access(1'b1, 1'b0, "R4 write default");
    run(11, "R4 write default");

    write_cfg(32'hFFFF_FFFF, "R2 all ones");
    check_val("R2 reserved bits", cfg_rd_data, 32'h771F_1FFF);
    write_cfg(32'h3403_0712, "R2 field write");
    check_val("R2 field layout", cfg_rd_data, 32'h3403_0712);
    start_access(1'b1, 1'b0, "R4 write off 3");
    run(7, "R4 write off 3");
    start_access(1'b0, 1'b0, "R3 read off 7");
    run(9, "R3 read off 7");

    write_cfg(32'h3401_0712, "R5 cfg");
    start_access(1'b1, 1'b0, "R5 close below open");
    run(6, "R5 close below open");
    write_cfg(32'h3402_0712, "R5 cfg");
    start_access(1'b1, 1'b0, "R5 close equals open");
    run(6, "R5 close equals open");

    write_cfg(32'h3403_1F10, "R6 cfg");
    start_access(1'b0, 1'b0, "R6 saturation");
    run(40, "R6 saturation");

    write_cfg(32'h3403_0693, "R7 cfg");
    start_access(1'b0, 1'b0, "R7 half delay");
    run(10, "R7 half delay");
    write_cfg(32'h3403_0613, "R7 cfg clear");
    start_access(1'b0, 1'b0, "R7 no delay");
    run(9, "R7 no delay");

    start_access(1'b0, 1'b1, "R8 first-phase read");
    run(7, "R8 first-phase read");
    start_access(1'b1, 1'b1, "R8 first-phase write");
    run(7, "R8 first-phase write");

    write_cfg(32'h3404_0611, "R9 cfg");
    start_access(1'b0, 1'b0, "R9 first access");
    run(2, "R9 first access");
    start_access(1'b1, 1'b0, "R9 restart as write");
    run(8, "R9 restart as write");
    write_cfg(32'h3404_0691, "R9 cfg delay");
    start_access(1'b0, 1'b0, "R9 delayed first");
    run(3, "R9 delayed first");
    write_cfg(32'h3404_0611, "R9 cfg");
    start_access(1'b1, 1'b0, "R9 restart no delay");
    run(7, "R9 restart no delay");

    start_access(1'b0, 1'b0, "R10 held timing");
    write_cfg(32'h3404_0211, "R10 write during access");
    run(8, "R10 held timing");
    check_val("R10 new word", cfg_rd_data, 32'h3404_0211);
    start_access(1'b0, 1'b0, "R10 next access");
    run(6, "R10 next access");

    run(3, "R11 tail");
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule